// File: doc/BRIEF.md
# SPI Wait-State Scratch Target

This block is an SPI target that serves framed transactions from a host. Each transaction starts with a four-byte command header. The first header byte gives the direction and the payload length. The next three bytes are taken in and have no effect. While the header is shifted in, the target answers with a fixed pattern. The last byte of that pattern has its least significant bit cleared, which tells the host that a wait phase follows.

During the wait phase the target returns a hold byte for as long as its `ready` input is low. It returns a release byte on the first byte boundary after `ready` is seen high. The payload starts on the byte after the release byte. The payload is 1 to 64 bytes and moves between the host and an internal 64-byte scratch buffer.

The serial pins are oversampled by the system clock, which runs at least four times faster than SCLK. The link uses mode 0: data is sampled on the rising edge, changed on the falling edge, most significant bit first. After the last payload byte the target is ready for the next header at once. Deasserting chip select at any time ends the transaction.

Top module: `spi_wait_target`

## Requirements
- R1: After reset MISO is high while chip select is inactive, and every scratch byte reads as 0x00 until written.
- R2: While the four header bytes are clocked in, MISO returns 0xFF, 0xFF, 0xFF, 0xFE in that order.
- R3: Each wait-phase byte is 0x00 when `ready` was low at the end of the previous byte and 0x01 when it was high. The byte after 0x01 is the first payload byte.
- R4: Payload length is header byte 0 bits [5:0] plus one (1 to 64), and bit 6 of that byte has no effect.
- R5: With header byte 0 bit 7 = 1 (read), the payload returns scratch bytes 0..N-1 in order, and MOSI during the payload does not change the buffer.
- R6: With bit 7 = 0 (write), payload byte k is stored at scratch index k, and MISO returns 0x00 for every write payload byte.
- R7: After the last payload byte, and with chip select still active, the next byte starts a new header that is answered as in R2.
- R8: The three address bytes of the header have no effect on the transfer.
- R9: Deasserting chip select returns the target to header phase. Write bytes completed before that remain stored, and the rest of that payload is not written.
- R10: Bytes are shifted MSB first, and MISO changes only after a falling SCLK edge or when chip select goes inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| ready | input | 1 | High when the target may end the wait phase |
| miso | output | 1 | Serial data to the host |

## Verification
The bench builds the block with its default parameters: a 64-byte buffer, two synchroniser stages and a four-byte header. With these values the full six-bit length field can be driven, so the largest payload runs the payload index up to its top value of 63 and the last-byte compare sees its full width. The oversampling ratio is set to eight system cycles per SCLK half period. That leaves room for the synchroniser delay between a falling edge and the host's next sample.

// File: rtl/spi_wait_target.sv
module spi_wait_target #(
  parameter int BUF_BYTES   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int HDR_BYTES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  input  logic ready,
  output logic miso
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int HDR_W = $clog2(HDR_BYTES);
  localparam logic [HDR_W-1:0] HDR_LAST = HDR_W'(HDR_BYTES - 1);
  localparam logic [HDR_W-1:0] HDR_PEN  = HDR_W'(HDR_BYTES - 2);
  localparam logic [1:0] PH_HDR  = 2'd0;
  localparam logic [1:0] PH_WAIT = 2'd1;
  localparam logic [1:0] PH_PAY  = 2'd2;

  logic [SYNC_STAGES:0] sclk_q, cs_q, mosi_q;
  logic sclk_rise, sclk_fall, cs_act, mosi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC_STAGES-1:0], sclk};
      cs_q   <= {cs_q[SYNC_STAGES-1:0], cs_n};
      mosi_q <= {mosi_q[SYNC_STAGES-1:0], mosi};
    end

  assign sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_q[SYNC_STAGES];
  assign sclk_fall = ~sclk_q[SYNC_STAGES-1] & sclk_q[SYNC_STAGES];
  assign cs_act    = ~cs_q[SYNC_STAGES-1];
  assign mosi_s    = mosi_q[SYNC_STAGES-1];

  logic [1:0]       phase;
  logic [2:0]       bit_cnt;
  logic [6:0]       rx_sr;
  logic [7:0]       tx_sr, tx_next;
  logic             load_pend, dir_rd, rel_sent;
  logic [HDR_W-1:0] hdr_idx;
  logic [IDX_W-1:0] len, pay_idx, nxt_idx;
  logic [7:0]       mem [BUF_BYTES];

  logic       byte_done, buf_we;
  logic [7:0] rx_byte, wait_byte;

  assign byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sr, mosi_s};
  assign wait_byte = ready ? 8'h01 : 8'h00;
  assign nxt_idx   = pay_idx + 1'b1;
  assign buf_we    = byte_done & (phase == PH_PAY) & ~dir_rd;
  assign miso      = tx_sr[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= PH_HDR;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= 8'hFF;
      tx_next   <= 8'hFF;
      load_pend <= 1'b0;
      dir_rd    <= 1'b0;
      rel_sent  <= 1'b0;
      hdr_idx   <= '0;
      len       <= '0;
      pay_idx   <= '0;
    end else if (!cs_act) begin
      phase     <= PH_HDR;
      bit_cnt   <= '0;
      tx_sr     <= 8'hFF;
      load_pend <= 1'b0;
      rel_sent  <= 1'b0;
      hdr_idx   <= '0;
      pay_idx   <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sr   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        load_pend <= 1'b1;
        case (phase)
          PH_HDR: begin
            if (hdr_idx == '0) begin
              dir_rd <= rx_byte[7];
              len    <= rx_byte[IDX_W-1:0];
            end
            if (hdr_idx == HDR_LAST) begin
              phase    <= PH_WAIT;
              hdr_idx  <= '0;
              tx_next  <= wait_byte;
              rel_sent <= ready;
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
              tx_next <= (hdr_idx == HDR_PEN) ? 8'hFE : 8'hFF;
            end
          end
          PH_WAIT: begin
            if (rel_sent) begin
              phase    <= PH_PAY;
              pay_idx  <= '0;
              rel_sent <= 1'b0;
              tx_next  <= dir_rd ? mem[0] : 8'h00;
            end else begin
              tx_next  <= wait_byte;
              rel_sent <= ready;
            end
          end
          default: begin
            if (pay_idx == len) begin
              phase   <= PH_HDR;
              pay_idx <= '0;
              tx_next <= 8'hFF;
            end else begin
              pay_idx <= nxt_idx;
              tx_next <= dir_rd ? mem[nxt_idx] : 8'h00;
            end
          end
        endcase
      end
      if (sclk_fall) begin
        if (load_pend) begin
          tx_sr     <= tx_next;
          load_pend <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[6:0], 1'b1};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
    end else if (buf_we) begin
      mem[pay_idx] <= rx_byte;
    end
endmodule

module spi_wait_target_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miso,
  input logic             cs_act,
  input logic             sclk_fall,
  input logic [1:0]       phase,
  input logic             rel_sent,
  input logic             buf_we,
  input logic             dir_rd,
  input logic [IDX_W-1:0] pay_idx,
  input logic [IDX_W-1:0] len
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> miso) else $error("idle miso");                         // R1
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(miso) |-> $past(sclk_fall || !cs_act)) else $error("miso edge"); // R10
  AST_PAY_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) != 2'd2) |-> ($past(phase) == 2'd1 && $past(rel_sent)))
    else $error("payload entry");                                        // R3
  AST_PAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd2 |-> pay_idx <= len) else $error("payload index");      // R4
  AST_WRITE_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (!dir_rd && phase == 2'd2 && cs_act)) else $error("buffer write"); // R5
  AST_CS_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> phase == 2'd0) else $error("cs reset");                  // R9
endmodule

bind spi_wait_target spi_wait_target_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .phase(phase), .rel_sent(rel_sent), .buf_we(buf_we), .dir_rd(dir_rd),
  .pay_idx(pay_idx), .len(len)
);

// File: tb/test_spi_wait_target.sv
`timescale 1ns/1ps
module test_spi_wait_target;
  localparam time HALF = 40ns;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, ready = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [64];

  always #2.5ns clk = ~clk;

  spi_wait_target i_spi_wait_target (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .ready(ready), .miso(miso)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      #HALF;
      rx[b] = miso;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    #HALF;
  endtask

  task automatic cs_off();
    #HALF;
    cs_n = 1'b1;
    #(4 * HALF);
  endtask

  // header then wait phase; R2, R3, R8, R10 (0xFE only arrives intact MSB first)
  task automatic hdr_wait(input logic rd, input logic b6, input int n,
                          input logic [23:0] addr, input int nhold);
    logic [7:0] rx, hb [4];
    hb[0] = {rd, b6, 6'(n - 1)};
    hb[1] = addr[23:16]; hb[2] = addr[15:8]; hb[3] = addr[7:0];
    ready = (nhold == 0);
    for (int i = 0; i < 4; i++) begin
      xfer(hb[i], rx);
      chk("R2 header reply", rx, (i == 3) ? 8'hFE : 8'hFF);
    end
    for (int i = 0; i <= nhold; i++) begin
      if (i == nhold - 1) ready = 1'b1;
      xfer(8'h5A, rx);
      chk("R3 wait byte", rx, (i == nhold) ? 8'h01 : 8'h00);
    end
    ready = 1'b0;
  endtask

  task automatic rd_payload(input int n, input string tag);
    logic [7:0] rx;
    for (int i = 0; i < n; i++) begin
      xfer(8'(i * 29 + 3), rx);
      chk(tag, rx, model[i]);
    end
  endtask

  task automatic wr_payload(input int n, input int seed);
    logic [7:0] rx, d;
    for (int i = 0; i < n; i++) begin
      d = 8'(i * 37 + seed);
      xfer(d, rx);
      chk("R6 write reply", rx, 8'h00);
      model[i] = d;
    end
  endtask

  task automatic t_reset();
    chk("R1 idle miso", {7'd0, miso}, 8'h01);
    cs_on();
    hdr_wait(1'b1, 1'b0, 8, 24'h000000, 0);
    rd_payload(8, "R1 zero buffer");
    cs_off();
  endtask

  task automatic t_write_read();
    cs_on();
    hdr_wait(1'b0, 1'b0, 4, 24'hD40000, 2);
    wr_payload(4, 11);
    cs_off();
    cs_on();
    hdr_wait(1'b1, 1'b0, 4, 24'h123456, 1);
    rd_payload(4, "R8 read after write");
    cs_off();
  endtask

  task automatic t_full();
    cs_on();
    hdr_wait(1'b0, 1'b0, 64, 24'hFFFFFF, 3);
    wr_payload(64, 5);
    cs_off();
    cs_on();
    hdr_wait(1'b1, 1'b1, 64, 24'h00A5A5, 0);
    rd_payload(64, "R4 full read bit6 set");
    cs_off();
    cs_on();
    hdr_wait(1'b1, 1'b0, 64, 24'h000000, 0);
    rd_payload(64, "R5 read ignores mosi");
    cs_off();
  endtask

  task automatic t_back_to_back();
    cs_on();
    hdr_wait(1'b1, 1'b0, 1, 24'h000001, 0);
    rd_payload(1, "R4 length one");
    hdr_wait(1'b1, 1'b0, 2, 24'h000002, 1);
    rd_payload(2, "R7 second frame");
    cs_off();
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    cs_on();
    hdr_wait(1'b0, 1'b0, 4, 24'h000000, 0);
    xfer(8'hC1, rx); model[0] = 8'hC1;
    xfer(8'hC2, rx); model[1] = 8'hC2;
    mosi = 1'b1;
    #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    cs_off();
    chk("R9 idle after abort", {7'd0, miso}, 8'h01);
    cs_on();
    hdr_wait(1'b1, 1'b0, 4, 24'h000000, 0);
    rd_payload(4, "R9 partial write");
    cs_off();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    #23ns rst_n = 1'b1;
    #50ns;
    t_reset();
    t_write_read();
    t_full();
    t_back_to_back();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule